// File: doc/BRIEF.md
# Indexed Event Counter Bank

This block holds a small bank of wide event counters behind a narrow register window. One selector register picks the counter that the condition, count, snapshot and threshold registers act on. All other registers are shared by the whole bank. Each counter watches one of several event inputs, chosen by a condition number. Condition zero never counts, and that is the only way to park a single counter. A global run bit starts and stops the whole bank at once.

Software reads a wide counter without tearing. It first sets the snapshot bit in the control register, which freezes a copy of the selected counter. It then reads the two halves of that copy at leisure. Each counter also has a threshold. Reaching the threshold raises that counter's pending flag. Pending flags that are also enabled are OR-ed onto a single interrupt line. Clearing a pending flag by writing one also drops that counter's interrupt enable, so the handler has to re-arm it. A read-only information register describes how the bank was built.

Top module: `evt_counter_bank`

## Requirements
- R1: The selector register (address 0) keeps the low log2(NUM_CNT) bits of the value written and reads them back. Its value picks the counter that addresses 2, 3, 4, 5, 6, 7 and 8 act on.
- R2: A counter adds exactly one on each clock in which the run bit (control register address 1, bit 0) is 1, its condition is non-zero and the event input with that number is 1. While the run bit is 0, no counter changes.
- R3: A counter whose condition register (address 2) holds 0 never counts, whatever the event inputs do.
- R4: The count is written as a low word (address 3, bits 31:0) and a high word (address 4, which keeps CNT_W-32 bits). High-word bits above that width read as 0. A write takes priority over an increment in the same cycle. Carries from the low word ripple into the high word.
- R5: Writing the control register with bit 1 set copies the selected counter into the snapshot low (address 5) and snapshot high (address 6) registers. Later counting leaves the copy unchanged. Bit 1 reads 1 for the single cycle after the write and 0 afterwards.
- R6: Control bits 31:16 are stored as written and read back. Bits 15:2 read 0.
- R7: Each counter has a threshold, written at address 7 (low word) and address 8 (high word). An increment that makes the count equal to the threshold sets bit n of the pending register (address 10).
- R8: The interrupt output is 1 exactly when some counter n has both its pending bit and bit n of the interrupt-enable register (address 9) set.
- R9: Writing 1 to bit n of the pending register clears that pending bit and also bit n of the enable register. Bits written as 0 have no effect, and writing all ones clears every pending bit.
- R10: The information register (address 11) reads bit 0 = 1 (valid), bit 1 = interrupt support, bits 12:8 = NUM_CNT and bits 17:16 = (CNT_W-32)/16. With the default parameters it reads 0x00010403.
- R11: Read data appears on rd_data in the cycle after rd_en is sampled. Unmapped addresses read 0.
- R12: After reset, all counters, conditions, thresholds, enables, pending bits and control bits are 0, and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_i | input | NUM_EV | Event inputs, selected by condition number |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Read register address |
| rd_data | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt output |

## Verification
A write takes effect on the clock edge that samples it. An enabled event input held for K clock periods therefore adds exactly K, and a counter value read back one read later reflects every edge before that read. Read results arrive one cycle after the strobe. The driver queues each expected word, and the monitor pops it on the falling edge after the returning clock, so register state is compared at a fixed offset from the stimulus. The interrupt line is combinational from the pending and enable registers. It is sampled on the falling edge right after the edge that set or cleared those bits. The snapshot bit is read in the very next read after the control write, where it must still be 1.

// File: rtl/evt_bank_pkg.sv
// Package: shared register addresses for the indexed event counter bank.
// Assumes a 4-bit word address on the register window.
package evt_bank_pkg;
    typedef enum logic [3:0] {
        A_SEL   = 4'd0,
        A_CTRL  = 4'd1,
        A_COND  = 4'd2,
        A_CNTL  = 4'd3,
        A_CNTH  = 4'd4,
        A_SNPL  = 4'd5,
        A_SNPH  = 4'd6,
        A_THRL  = 4'd7,
        A_THRH  = 4'd8,
        A_IEN   = 4'd9,
        A_IACT  = 4'd10,
        A_INFO  = 4'd11
    } reg_addr_e;

    localparam int WORD_W = 32;
endpackage

// File: rtl/evt_count_slot.sv
// One counter of the bank: condition selector, wide count, threshold.
// Assumes 32 < CNT_W <= 64. The strobes are already qualified by the index.
module evt_count_slot #(
    parameter int NUM_EV = 16,
    parameter int CNT_W  = 48,
    localparam int COND_W = $clog2(NUM_EV),
    localparam int HI_W   = CNT_W - 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [NUM_EV-1:0] ev,
    input  logic              wr_cond,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_tlo,
    input  logic              wr_thi,
    input  logic [31:0]       wdata,
    output logic [COND_W-1:0] cond_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  thr_o,
    output logic              hit_o
);
    logic             inc;
    logic             load;
    logic [CNT_W-1:0] cnt_plus;

    // Purpose: decide whether this counter steps this cycle.
    always_comb begin
        inc      = run && (cond_o != '0) && ev[cond_o];
        load     = wr_lo || wr_hi;
        cnt_plus = cnt_o + 1'b1;
        hit_o    = inc && !load && (cnt_plus == thr_o);
    end

    // Purpose: condition selector register.
    always_ff @(posedge clk) begin
        if (!rst_n)       cond_o <= '0;
        else if (wr_cond) cond_o <= wdata[COND_W-1:0];
    end

    // Purpose: count register; software writes override counting.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_o <= '0;
        else if (wr_lo)  cnt_o[31:0] <= wdata;
        else if (wr_hi)  cnt_o[CNT_W-1:32] <= wdata[HI_W-1:0];
        else if (inc)    cnt_o <= cnt_plus;
    end

    // Purpose: interrupt threshold register, written in halves.
    always_ff @(posedge clk) begin
        if (!rst_n)      thr_o <= '0;
        else if (wr_tlo) thr_o[31:0] <= wdata;
        else if (wr_thi) thr_o[CNT_W-1:32] <= wdata[HI_W-1:0];
    end

    // R2: an enabled, selected event adds exactly one
    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cond_o != '0 && ev[cond_o] && !wr_lo && !wr_hi) |=> (cnt_o == $past(cnt_o) + 1'b1));

    // R3: condition zero never counts
    p_never_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_o == '0 && !wr_lo && !wr_hi) |=> $stable(cnt_o));

    // R2: stopped bank holds
    p_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_lo && !wr_hi) |=> $stable(cnt_o));
endmodule

// File: rtl/evt_irq_unit.sv
// Interrupt enable and pending flags for the whole bank.
// Assumes each hit pulses for one cycle; a set wins over a same-cycle clear.
module evt_irq_unit #(
    parameter int NUM_CNT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] hit,
    input  logic               wr_ien,
    input  logic               wr_iact,
    input  logic [NUM_CNT-1:0] wdata,
    output logic [NUM_CNT-1:0] ien_o,
    output logic [NUM_CNT-1:0] act_o,
    output logic               irq_o
);
    logic [NUM_CNT-1:0] clr_mask;

    // Purpose: write-one-to-clear mask from the pending register write.
    always_comb begin
        clr_mask = wr_iact ? wdata : '0;
        irq_o    = |(ien_o & act_o);
    end

    // Purpose: enable register; clearing a pending bit drops its enable.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_o <= '0;
        else if (wr_ien) ien_o <= wdata;
        else             ien_o <= ien_o & ~clr_mask;
    end

    // Purpose: pending flags, set by threshold hits and cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n) act_o <= '0;
        else        act_o <= (act_o & ~clr_mask) | hit;
    end

    // R9: cleared bits drop both pending and enable
    p_clear_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_iact |=> (((act_o | ien_o) & $past(wdata & ~hit)) == '0));

    // R8: interrupt needs an enable
    p_irq_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ien_o != '0));

    // R7: pending bits rise only on a hit
    p_set_on_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((act_o & ~$past(act_o) & ~$past(hit)) == '0));
endmodule

// File: rtl/evt_counter_bank.sv
// Top of the indexed event counter bank: register decode, snapshot,
// read-back mux, and one evt_count_slot per counter.
// Assumes single-cycle register writes and a registered read port.
module evt_counter_bank #(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 48,
    parameter int NUM_EV  = 16,
    parameter bit HAS_IRQ = 1'b1,
    localparam int IDX_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1,
    localparam int COND_W = $clog2(NUM_EV),
    localparam int HI_W   = CNT_W - 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev_i,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    input  logic [3:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic              irq_o
);
    import evt_bank_pkg::*;

    localparam logic [1:0] SIZE_CODE = 2'((CNT_W - 32) / 16);
    localparam logic [4:0] CNT_CODE  = 5'(NUM_CNT);

    logic [IDX_W-1:0]  sel_q;
    logic              run_q;
    logic              snap_q;
    logic [15:0]       ctrl_hi_q;
    logic [63:0]       snap_val_q;

    logic [COND_W-1:0] cond_a [NUM_CNT];
    logic [CNT_W-1:0]  cnt_a  [NUM_CNT];
    logic [CNT_W-1:0]  thr_a  [NUM_CNT];
    logic [NUM_CNT-1:0] hit_v;
    logic [NUM_CNT-1:0] ien_v;
    logic [NUM_CNT-1:0] act_v;
    logic              irq_raw;

    logic wr_ctrl, wr_sel;
    logic [31:0] info_word;

    // Purpose: decode the shared register writes.
    always_comb begin
        wr_sel    = wr_en && (wr_addr == A_SEL);
        wr_ctrl   = wr_en && (wr_addr == A_CTRL);
        info_word = {14'd0, SIZE_CODE, 3'd0, CNT_CODE, 6'd0, HAS_IRQ, 1'b1};
    end

    // Purpose: selector register.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (wr_sel) sel_q <= wr_data[IDX_W-1:0];
    end

    // Purpose: control register, run bit and self-clearing snapshot bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            snap_q    <= 1'b0;
            ctrl_hi_q <= '0;
        end else if (wr_ctrl) begin
            run_q     <= wr_data[0];
            snap_q    <= wr_data[1];
            ctrl_hi_q <= wr_data[31:16];
        end else begin
            snap_q    <= 1'b0;
        end
    end

    // Purpose: snapshot copy of the selected counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                      snap_val_q <= '0;
        else if (wr_ctrl && wr_data[1])  snap_val_q <= 64'(cnt_a[sel_q]);
    end

    // Purpose: one counter slot per index, strobes qualified by the selector.
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_slot
        logic me;
        always_comb me = wr_en && (sel_q == IDX_W'(g));
        evt_count_slot #(.NUM_EV(NUM_EV), .CNT_W(CNT_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run_q),
            .ev     (ev_i),
            .wr_cond(me && wr_addr == A_COND),
            .wr_lo  (me && wr_addr == A_CNTL),
            .wr_hi  (me && wr_addr == A_CNTH),
            .wr_tlo (me && wr_addr == A_THRL),
            .wr_thi (me && wr_addr == A_THRH),
            .wdata  (wr_data),
            .cond_o (cond_a[g]),
            .cnt_o  (cnt_a[g]),
            .thr_o  (thr_a[g]),
            .hit_o  (hit_v[g])
        );
    end

    evt_irq_unit #(.NUM_CNT(NUM_CNT)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit_v),
        .wr_ien (wr_en && wr_addr == A_IEN),
        .wr_iact(wr_en && wr_addr == A_IACT),
        .wdata  (wr_data[NUM_CNT-1:0]),
        .ien_o  (ien_v),
        .act_o  (act_v),
        .irq_o  (irq_raw)
    );

    // Purpose: gate the interrupt line by the build-time support bit.
    always_comb irq_o = HAS_IRQ && irq_raw;

    // Purpose: registered read-back mux.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            case (rd_addr)
                A_SEL:   rd_data <= 32'(sel_q);
                A_CTRL:  rd_data <= {ctrl_hi_q, 14'd0, snap_q, run_q};
                A_COND:  rd_data <= 32'(cond_a[sel_q]);
                A_CNTL:  rd_data <= cnt_a[sel_q][31:0];
                A_CNTH:  rd_data <= 32'(cnt_a[sel_q][CNT_W-1:32]);
                A_SNPL:  rd_data <= snap_val_q[31:0];
                A_SNPH:  rd_data <= snap_val_q[63:32];
                A_THRL:  rd_data <= thr_a[sel_q][31:0];
                A_THRH:  rd_data <= 32'(thr_a[sel_q][CNT_W-1:32]);
                A_IEN:   rd_data <= 32'(ien_v);
                A_IACT:  rd_data <= 32'(act_v);
                A_INFO:  rd_data <= info_word;
                default: rd_data <= '0;
            endcase
        end
    end

    // R5: snapshot bit clears itself after one cycle
    p_snap_self_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_q && !(wr_ctrl && wr_data[1])) |=> !snap_q);

    // R5: snapshot copy holds unless a new snapshot is taken
    p_snap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ctrl && wr_data[1]) |=> $stable(snap_val_q));

    // R11: read data only changes after a read strobe
    p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: tb/tb_evt_counter_bank.sv
// Scoreboard bench: driver tasks queue expected read words, a monitor pops
// and compares them one cycle after each read strobe.
module tb_evt_counter_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ev_i = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic rd_en_q = 1'b0;
    logic [31:0] q_exp [$];
    string       q_tag [$];

    evt_counter_bank dut (
        .clk(clk), .rst_n(rst_n), .ev_i(ev_i),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) rd_en_q <= rd_en;

    // Monitor: compare each returning read against the queued expectation.
    always @(negedge clk) begin
        if (rd_en_q && q_exp.size() > 0) begin
            logic [31:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            checks++;
            if (rd_data !== e) begin
                errors++;
                $display("FAIL %s: got 0x%08h expected 0x%08h", t, rd_data, e);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
        q_exp.push_back(e);
        q_tag.push_back(t);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] m, input int k);
        ev_i = m;
        repeat (k) @(negedge clk);
        ev_i = '0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        checks++;
        if (irq_o !== e) begin
            errors++;
            $display("FAIL %s: irq got %0b expected %0b", t, irq_o, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk_irq(1'b0, "R12 irq after reset");
        rd(4'd1, 32'h0, "R12 ctrl after reset");
        rd(4'd3, 32'h0, "R12 count after reset");
        rd(4'd9, 32'h0, "R12 enable after reset");
        // R10 build information
        rd(4'd11, 32'h0001_0403, "R10 info register");
        // R11 unmapped address
        rd(4'd15, 32'h0, "R11 unmapped read");

        // R2 counting on counter 0 via event 5
        wr(4'd0, 32'd0);
        wr(4'd2, 32'd5);
        rd(4'd2, 32'd5, "R1 condition readback");
        wr(4'd1, 32'h1);
        pulse(16'h0020, 7);
        rd(4'd3, 32'd7, "R2 seven events counted");
        wr(4'd1, 32'h0);
        pulse(16'h0020, 4);
        rd(4'd3, 32'd7, "R2 stopped bank holds");
        wr(4'd1, 32'h1);
        wr(4'd2, 32'd0);
        pulse(16'hFFFF, 3);
        rd(4'd3, 32'd7, "R3 condition zero never counts");

        // R4 count halves on counter 2
        wr(4'd0, 32'd2);
        wr(4'd3, 32'hDEAD_BEEF);
        wr(4'd4, 32'hFFFF_1234);
        rd(4'd4, 32'h0000_1234, "R4 high word width");
        rd(4'd3, 32'hDEAD_BEEF, "R4 low word");

        // R5 snapshot
        wr(4'd1, 32'h3);
        rd(4'd1, 32'h3, "R5 snapshot bit visible one cycle");
        rd(4'd1, 32'h1, "R5 snapshot bit self-clears");
        rd(4'd6, 32'h0000_1234, "R5 snapshot high");
        rd(4'd5, 32'hDEAD_BEEF, "R5 snapshot low");
        wr(4'd2, 32'd5);
        pulse(16'h0020, 3);
        rd(4'd5, 32'hDEAD_BEEF, "R5 snapshot frozen while counting");
        rd(4'd3, 32'hDEAD_BEF2, "R2 counter 2 advanced");

        // R1 index switching
        wr(4'd0, 32'd0);
        rd(4'd3, 32'd7, "R1 counter 0 kept its value");
        rd(4'd0, 32'd0, "R1 selector readback");
        wr(4'd0, 32'hFFFF_FFF6);
        rd(4'd0, 32'd2, "R1 selector keeps low bits");
        rd(4'd2, 32'd5, "R1 counter 2 condition");

        // R4 carry into high word
        wr(4'd3, 32'hFFFF_FFFF);
        wr(4'd4, 32'h0);
        pulse(16'h0020, 1);
        rd(4'd3, 32'h0, "R4 low wraps");
        rd(4'd4, 32'h1, "R4 carry into high");

        // R6 control upper bits
        wr(4'd1, 32'hABCD_FFFD);
        rd(4'd1, 32'hABCD_0001, "R6 upper bits kept, middle zero");

        // R7/R8 threshold interrupt on counter 1 via event 3
        wr(4'd0, 32'd1);
        wr(4'd2, 32'd3);
        wr(4'd3, 32'd0);
        wr(4'd4, 32'd0);
        wr(4'd7, 32'd5);
        wr(4'd8, 32'd0);
        rd(4'd7, 32'd5, "R7 threshold readback");
        wr(4'd9, 32'h2);
        pulse(16'h0008, 4);
        chk_irq(1'b0, "R7 below threshold no irq");
        rd(4'd10, 32'h0, "R7 no pending below threshold");
        pulse(16'h0008, 1);
        chk_irq(1'b1, "R8 irq at threshold");
        rd(4'd10, 32'h2, "R7 pending bit 1 set");

        // R9 write-one-to-clear
        wr(4'd10, 32'h1);
        chk_irq(1'b1, "R9 zero bits have no effect");
        rd(4'd10, 32'h2, "R9 pending kept");
        wr(4'd10, 32'h2);
        chk_irq(1'b0, "R9 irq dropped after clear");
        rd(4'd10, 32'h0, "R9 pending cleared");
        rd(4'd9, 32'h0, "R9 enable cleared with pending");

        // R8 pending without enable, then enable
        wr(4'd3, 32'd0);
        pulse(16'h0008, 5);
        rd(4'd10, 32'h2, "R7 pending set again");
        chk_irq(1'b0, "R8 no irq without enable");
        wr(4'd9, 32'h2);
        chk_irq(1'b1, "R8 irq once enabled");
        wr(4'd10, 32'hFFFF_FFFF);
        chk_irq(1'b0, "R9 all ones clears all");
        rd(4'd10, 32'h0, "R9 all pending cleared");

        @(negedge clk);
        finish_run();
    end
endmodule